// File: doc/BRIEF.md
# Gray-coded baud tick generator

This block divides the system clock down to a periodic strobe that paces a serial transmitter and receiver at a common bit rate. It emits one tick every N clocks. N is chosen from a small set of standard bit rates and an oversampling factor. The same strobe feeds both directions, so the two sides cannot drift apart in rate.

The divider state is a Gray-coded count rather than a binary one. Each step decodes the stored code to binary, adds one, and re-encodes the sum before it is registered. As a result, only a single flip-flop of the count changes on an ordinary step, which lowers switching activity in the divider. The terminal value is recognised directly in the Gray domain.

The current code is brought out on a port for test. A change of rate select restarts the count, so the first period at the new rate is a whole period.

Top module: `gray_baud_tick`

## Requirements
- R1: The count is held in Gray code. n clocks after the count leaves zero, count_g equals n XOR (n >> 1).
- R2: Between two consecutive nonzero count values exactly one bit of count_g differs. Only a return to zero may change more bits.
- R3: rate_sel codes 0, 1, 2, 3 and 4 select 1200, 4800, 9600, 19200 and 38400 bit/s. The divisor D is CLK_HZ / (rate × OVERSAMPLE) rounded to nearest, and ticks repeat every D clocks.
- R4: When the count equals the Gray code of D−1, the next clock returns it to zero.
- R5: tick is high for exactly one clock, and only while count_g equals the Gray code of D−1 for the selected rate.
- R6: Reset is synchronous and active low. It clears count_g to zero and keeps tick low while asserted. The first tick comes D−1 clocks after the first clock with reset released.
- R7: A change of rate_sel forces the count to zero on the next clock. The first tick at the new rate comes exactly D clocks after the change is applied, and no tick occurs in between.
- R8: rate_sel codes 5, 6 and 7 behave as code 4 (38400 bit/s).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rate_sel | input | 3 | Bit-rate select code |
| tick | output | 1 | One-clock strobe at the end of each period |
| count_g | output | CNT_W | Current Gray-coded count, for test |

## Verification
Several properties are checked on every clock by the assertions: the single-bit step between nonzero counts, the return to zero after each tick, the one-clock width of tick, the reset clearing, and the restart on a select change. The exact period for each rate code depends on the rounded divisor table, so only the bench scenarios can confirm it. The same holds for the placement of the first tick after a reset release or a rate change, and for the mapping of the spare codes. The bench does this with a queue of predicted tick cycles.

// File: rtl/gbt_pkg.sv
`timescale 1ns/1ps
// gbt_pkg: constants and helper functions shared by the baud tick divider.
// Assumes a system clock fast enough that every divisor is at least 2.
package gbt_pkg;

    localparam int unsigned SEL_W     = 3;
    localparam int unsigned NUM_RATES = 5;
    localparam int unsigned BASE_RATE = 1200;

    // Multiples of BASE_RATE for select codes 0..NUM_RATES-1.
    localparam int unsigned RATE_MULT [NUM_RATES] = '{1, 4, 8, 16, 32};

    // Divisor rounded to the nearest integer.
    function automatic int unsigned div_for(input int unsigned clk_hz,
                                            input int unsigned rate,
                                            input int unsigned os);
        int unsigned step;
        step = rate * os;
        return (clk_hz + step / 2) / step;
    endfunction

endpackage

// File: rtl/gbt_rate_rom.sv
`timescale 1ns/1ps
// gbt_rate_rom: maps a rate select code to the Gray code of the last count
// value of a period (divisor - 1). Codes past the table use the last entry.
// Assumes CNT_W is wide enough for the largest divisor.
module gbt_rate_rom
    import gbt_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 200_000_000,
    parameter int unsigned OVERSAMPLE = 16,
    parameter int unsigned CNT_W      = 14
) (
    input  logic [SEL_W-1:0] rate_sel,
    output logic [CNT_W-1:0] term_g
);

    logic [CNT_W-1:0] term_tab [NUM_RATES];

    // One constant terminal code per selectable rate.
    for (genvar i = 0; i < NUM_RATES; i++) begin : g_rate
        localparam int unsigned DIV  = div_for(CLK_HZ, BASE_RATE * RATE_MULT[i], OVERSAMPLE);
        localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);
        assign term_tab[i] = LAST ^ (LAST >> 1);
    end

    // Select the entry, clamping spare codes to the fastest rate.
    always_comb begin
        if (rate_sel >= SEL_W'(NUM_RATES)) begin
            term_g = term_tab[NUM_RATES-1];
        end else begin
            term_g = term_tab[rate_sel];
        end
    end

endmodule

// File: rtl/gbt_gray_inc.sv
`timescale 1ns/1ps
// gbt_gray_inc: next Gray code after cur_g (decode, add one, re-encode).
// Purely combinational; wraps modulo 2**W.
module gbt_gray_inc #(
    parameter int unsigned W = 14
) (
    input  logic [W-1:0] cur_g,
    output logic [W-1:0] nxt_g
);

    logic [W-1:0] bin;
    logic [W-1:0] bin_inc;

    // Decode: each binary bit is the XOR of all Gray bits at or above it.
    for (genvar i = 0; i < W; i++) begin : g_dec
        assign bin[i] = ^cur_g[W-1:i];
    end

    assign bin_inc = bin + W'(1);

    // Encode: each Gray bit is the XOR of adjacent binary bits.
    for (genvar i = 0; i < W; i++) begin : g_enc
        if (i == W - 1) begin : g_top
            assign nxt_g[i] = bin_inc[i];
        end else begin : g_mid
            assign nxt_g[i] = bin_inc[i] ^ bin_inc[i+1];
        end
    end

endmodule

// File: rtl/gbt_term_match.sv
`timescale 1ns/1ps
// gbt_term_match: flags the last count value of a period, compared
// directly in the Gray domain (no decode on the compare path).
module gbt_term_match #(
    parameter int unsigned W = 14
) (
    input  logic [W-1:0] cur_g,
    input  logic [W-1:0] term_g,
    output logic         hit
);

    // Equality of two Gray words.
    assign hit = (cur_g == term_g);

endmodule

// File: rtl/gray_baud_tick.sv
`timescale 1ns/1ps
// gray_baud_tick: divides clk to a one-clock tick at the selected bit rate
// times OVERSAMPLE. The count register holds Gray code. Reset is synchronous,
// active low. A change of rate_sel restarts the count from zero.
module gray_baud_tick
    import gbt_pkg::*;
#(
    parameter  int unsigned CLK_HZ     = 200_000_000,
    parameter  int unsigned OVERSAMPLE = 16,
    localparam int unsigned CNT_W      = $clog2(div_for(CLK_HZ, BASE_RATE, OVERSAMPLE))
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] rate_sel,
    output logic             tick,
    output logic [CNT_W-1:0] count_g
);

    logic [CNT_W-1:0] cnt_g;
    logic [CNT_W-1:0] nxt_g;
    logic [CNT_W-1:0] term_g;
    logic [SEL_W-1:0] sel_q;
    logic             hit;
    logic             restart;

    gbt_rate_rom #(
        .CLK_HZ    (CLK_HZ),
        .OVERSAMPLE(OVERSAMPLE),
        .CNT_W     (CNT_W)
    ) u_rom (
        .rate_sel(rate_sel),
        .term_g  (term_g)
    );

    gbt_gray_inc #(.W(CNT_W)) u_inc (
        .cur_g(cnt_g),
        .nxt_g(nxt_g)
    );

    gbt_term_match #(.W(CNT_W)) u_match (
        .cur_g (cnt_g),
        .term_g(term_g),
        .hit   (hit)
    );

    assign restart = (rate_sel != sel_q);

    // Remember the select applied in the previous cycle.
    always_ff @(posedge clk) begin
        sel_q <= rate_sel;
    end

    // Gray count: clear on reset, restart or terminal, else step by one code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_g <= '0;
        end else if (restart || hit) begin
            cnt_g <= '0;
        end else begin
            cnt_g <= nxt_g;
        end
    end

    // Strobe at terminal count, suppressed by reset or a pending restart.
    assign tick    = rst_n && hit && !restart;
    assign count_g = cnt_g;

endmodule

// File: rtl/gray_baud_tick_chk.sv
`timescale 1ns/1ps
// gray_baud_tick_chk: clocked properties for gray_baud_tick, bound below.
module gray_baud_tick_chk #(
    parameter int unsigned CNT_W = 14,
    parameter int unsigned SEL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SEL_W-1:0] rate_sel,
    input logic             tick,
    input logic [CNT_W-1:0] count_g
);

    // R2: a nonzero count differs from its predecessor in one bit.
    p_one_bit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && count_g != '0) |-> $countones(count_g ^ $past(count_g)) == 1);

    // R4: after a tick the count is back at zero.
    p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> count_g == '0);

    // R5: tick never lasts two clocks.
    p_tick_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R6: reset clears the count.
    p_reset_clear_r6: assert property (@(posedge clk)
        !rst_n |=> count_g == '0);

    // R6: no tick while reset is held.
    p_reset_quiet_r6: assert property (@(posedge clk)
        !rst_n |-> !tick);

    // R7: a select change restarts the count.
    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel != $past(rate_sel)) |=> count_g == '0);

endmodule

bind gray_baud_tick gray_baud_tick_chk #(
    .CNT_W(CNT_W),
    .SEL_W(gbt_pkg::SEL_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rate_sel(rate_sel),
    .tick    (tick),
    .count_g (count_g)
);

// File: tb/sim_gray_baud_tick.sv
`timescale 1ns/1ps
module sim_gray_baud_tick;

    localparam int unsigned CLK_HZ = 200_000_000;
    localparam int unsigned OS     = 16;
    localparam int unsigned W      = $clog2((CLK_HZ + 9600) / 19200);

    logic         clk   = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   sel   = 3'd4;
    logic         tick;
    logic [W-1:0] cnt;

    int     checks = 0;
    int     errors = 0;
    longint cyc    = 0;
    longint exp_q [$];
    bit     done   = 1'b0;

    gray_baud_tick #(.CLK_HZ(CLK_HZ), .OVERSAMPLE(OS)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .rate_sel(sel),
        .tick    (tick),
        .count_g (cnt)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc++;

    function automatic int unsigned exp_div(input logic [2:0] code);
        int unsigned r;
        case (code)
            3'd0:    r = 1200;
            3'd1:    r = 4800;
            3'd2:    r = 9600;
            3'd3:    r = 19200;
            default: r = 38400;   // R8: spare codes
        endcase
        return (CLK_HZ + r * OS / 2) / (r * OS);
    endfunction

    function automatic logic [W-1:0] to_gray(input longint n);
        logic [W-1:0] b;
        b = W'(n);
        return b ^ (b >> 1);
    endfunction

    function automatic longint from_gray(input logic [W-1:0] g);
        longint b;
        b = 0;
        for (int i = W - 1; i >= 0; i--) begin
            b = (b << 1) | longint'(g[i] ^ b[0]);
        end
        return b;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor: per-cycle checks and scoreboard of predicted tick cycles.
    logic [W-1:0] prev_cnt = '0;
    bit           prev_ok  = 1'b0;
    logic [2:0]   prev_sel = 3'd0;
    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                chk(cnt == '0, "R6", "count in reset", longint'(cnt), 0);
                chk(!tick, "R6", "tick in reset", longint'(tick), 0);
            end else begin
                chk(tick == (cnt == to_gray(exp_div(sel) - 1)), "R5", "tick vs terminal",
                    longint'(tick), longint'(cnt == to_gray(exp_div(sel) - 1)));
                if (prev_ok && prev_sel == sel) begin
                    if (cnt == '0) begin
                        chk(prev_cnt == to_gray(exp_div(sel) - 1), "R4", "wrap source",
                            longint'(prev_cnt), longint'(to_gray(exp_div(sel) - 1)));
                    end else begin
                        chk(from_gray(cnt) == from_gray(prev_cnt) + 1, "R1", "gray step value",
                            from_gray(cnt), from_gray(prev_cnt) + 1);
                        chk($countones(cnt ^ prev_cnt) == 1, "R2", "bits changed",
                            $countones(cnt ^ prev_cnt), 1);
                    end
                end
                if (exp_q.size() != 0 && cyc > exp_q[0]) begin
                    chk(1'b0, "R3", "missed tick", cyc, exp_q[0]);
                    void'(exp_q.pop_front());
                end
                if (tick) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R7", "unexpected tick", cyc, -1);
                    end else begin
                        chk(cyc == exp_q[0], "R3", "tick cycle", cyc, exp_q[0]);
                        void'(exp_q.pop_front());
                    end
                end
            end
            prev_cnt = cnt;
            prev_ok  = rst_n;
            prev_sel = sel;
        end
    end

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // Driver: apply a code and predict n ticks D, 2D, ... after it.
    task automatic run_rate(input logic [2:0] code, input int n);
        longint base;
        @(negedge clk);
        #1;
        sel  = code;
        base = cyc;
        for (int k = 1; k <= n; k++) exp_q.push_back(base + longint'(exp_div(code)) * k);
        drain();
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "R3", "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        longint base;
        repeat (5) @(negedge clk);
        // R6: reset state
        chk(cnt == '0 && !tick, "R6", "reset state", longint'(cnt), 0);
        #1;
        rst_n = 1'b1;
        base  = cyc;
        // R6: first tick D-1 after release; R3: then every D
        for (int k = 0; k < 3; k++) exp_q.push_back(base + exp_div(3'd4) - 1 + longint'(exp_div(3'd4)) * k);
        drain();

        // R3/R7: each standard rate, period and first tick after change
        run_rate(3'd3, 2);
        run_rate(3'd2, 2);
        run_rate(3'd1, 2);
        run_rate(3'd0, 2);
        // R8: spare codes run at the fastest rate
        run_rate(3'd7, 2);
        run_rate(3'd5, 1);

        // R7: change mid-period, R1: count value after restart
        @(negedge clk); #1; sel = 3'd4;
        repeat (100) @(negedge clk);
        #1;
        sel  = 3'd3;
        base = cyc;
        exp_q.push_back(base + exp_div(3'd3));
        repeat (10) @(negedge clk);
        chk(cnt == to_gray(9), "R1", "count 9 steps after restart", longint'(cnt), longint'(to_gray(9)));
        drain();

        // R6: reset in mid-period
        repeat (200) @(negedge clk);
        #1;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(cnt == '0 && !tick, "R6", "mid-run reset", longint'(cnt), 0);
        #1;
        rst_n = 1'b1;
        base  = cyc;
        exp_q.push_back(base + exp_div(3'd3) - 1);
        exp_q.push_back(base + 2 * exp_div(3'd3) - 1);
        drain();
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule